// File: doc/BRIEF.md
# Lockable Watchdog Timer with Early-Warning Interrupt

This block is a memory-mapped watchdog. A 32-bit down-counter steps once per rising edge of a slow 32768 Hz clock, which gives 32768 steps per second. The registers are held in the bus clock domain. Software writes a timeout and a separate early-warning (pre-timeout) threshold, each as two 16-bit halves. It then starts the counter. When the remaining count falls to the threshold, an interrupt flag is raised. When the count reaches zero, an expiry flag is raised. That flag drives a reset request.

A key register protects every other register against stray writes. The block leaves reset locked. The slow clock is brought into the bus domain through a synchronizer and an edge detector. A new value written to the load registers reaches the counter only after a short handover measured in slow-clock edges, and a status bit shows that the handover is still in progress. Writing the load registers again while the counter runs restarts the count. This is the keep-alive action.

Top module: `wdt_top`

## Requirements
- R1: After reset the block is locked (the key register at 0x20 reads 1), the control register (0x08) reads 0, raw status (0x10) reads 0, count (0x18/0x1C) reads 0, and `irq_o` and `rst_req_o` are low.
- R2: A write of 0xE551 (low 16 bits) to 0x20 unlocks the block, and any other value written there locks it. While the block is locked, writes to every other offset are ignored and their read-back stays unchanged. The key register reads 1 when locked and 0 when unlocked.
- R3: Each 32-bit value is split into halves: bits 31:16 in the high register and bits 15:0 in the low register. The timeout uses 0x04/0x00, the threshold uses 0x30/0x2C, and the live count reads back through 0x1C/0x18. The mask register is 0x14, and the control bits are 0 interrupt enable, 1 run, 2 threshold mode, 3 reset enable.
- R4: A write to any of the four load registers sets raw status bit 4 (busy) and restarts the handover. On the third synchronized slow-clock rising edge after the last such write, the counter and the active threshold take the loaded values, and busy clears on that same edge.
- R5: While control bit 1 is set, the count drops by exactly one per synchronized slow-clock rising edge and then holds at zero. While bit 1 is clear, the count holds.
- R6: With control bit 2 set, raw status bit 0 is set on the step at which the count becomes equal to the active threshold.
- R7: With control bit 2 clear, the threshold is not used, and raw status bit 0 is set on the step at which the count becomes zero.
- R8: Raw status bit 3 is set on the step at which the count becomes zero. `rst_req_o` is raw bit 3 AND control bit 3.
- R9: `irq_o` is raw bit 0 AND control bit 0 AND NOT mask bit 0.
- R10: Writing a 1 to bit 0 or bit 3 of 0x0C clears raw bit 0 or raw bit 3. If a new event arrives on the same edge, the flag stays set. 0x0C reads 0.
- R11: Reloading the timeout while the counter runs restarts the count from the new value once the handover ends. This is the keep-alive action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state is registered on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lf_clk | input | 1 | Slow 32768 Hz reference, asynchronous to clk |
| bus_we | input | 1 | Write strobe for one clk cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq_o | output | 1 | Early-warning interrupt |
| rst_req_o | output | 1 | Expiry reset request |

## Verification
Every cycle, the assertions check that the count changes only by a single step or through a handover, and that busy falls only on a handover edge. They also check that an event always leaves its raw flag set, that a locked write leaves the control bits alone, and that neither output is high without its raw flag. Only the bench scenarios can show the exact cycle at which the handover completes, the threshold-versus-zero choice of the two modes, keep-alive restarts, and the same-edge priority between a clear and a new event. The bench checks these against a behavioural model on every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W  = 32;
  localparam int HALF_W = CNT_W / 2;
  localparam logic [HALF_W-1:0] UNLOCK_KEY = 16'hE551;

  // byte offsets of the register window
  localparam int OFF_LD_LO  = 'h00;
  localparam int OFF_LD_HI  = 'h04;
  localparam int OFF_CTRL   = 'h08;
  localparam int OFF_CLR    = 'h0C;
  localparam int OFF_RAW    = 'h10;
  localparam int OFF_MASK   = 'h14;
  localparam int OFF_CNT_LO = 'h18;
  localparam int OFF_CNT_HI = 'h1C;
  localparam int OFF_LOCK   = 'h20;
  localparam int OFF_PRE_LO = 'h2C;
  localparam int OFF_PRE_HI = 'h30;

  // flag bit positions shared by raw status and clear
  localparam int BIT_INT  = 0;
  localparam int BIT_RST  = 3;
  localparam int BIT_BUSY = 4;

  typedef struct packed {
    logic rst_en;    // bit 3
    logic new_mode;  // bit 2
    logic run;       // bit 1
    logic int_en;    // bit 0
  } ctrl_t;

  function automatic logic [CNT_W-1:0] join_halves(input logic [HALF_W-1:0] hi,
                                                   input logic [HALF_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [HALF_W-1:0] upper_half(input logic [CNT_W-1:0] v);
    return v[CNT_W-1:HALF_W];
  endfunction

  function automatic logic [HALF_W-1:0] lower_half(input logic [CNT_W-1:0] v);
    return v[HALF_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction
endpackage

// File: rtl/wdt_lf_sync.sv
module wdt_lf_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lf_clk,
  output logic tick
);
  logic [SYNC_STAGES-1:0] stage_q;
  logic                   last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      last_q  <= 1'b0;
    end else begin
      stage_q[0] <= lf_clk;
      last_q     <= stage_q[SYNC_STAGES-1];
    end
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= 1'b0;
      else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign tick = stage_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              raw_int,
  input  logic              raw_rst,
  input  logic              busy,
  output ctrl_t             ctrl,
  output logic              mask_int,
  output logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  pre_val,
  output logic              load_wr,
  output logic              clr_int,
  output logic              clr_rst,
  output logic              locked
);
  localparam logic [ADDR_W-1:0] A_LD_LO  = ADDR_W'(OFF_LD_LO);
  localparam logic [ADDR_W-1:0] A_LD_HI  = ADDR_W'(OFF_LD_HI);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(OFF_CLR);
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFF_RAW);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(OFF_CNT_LO);
  localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(OFF_CNT_HI);
  localparam logic [ADDR_W-1:0] A_LOCK   = ADDR_W'(OFF_LOCK);
  localparam logic [ADDR_W-1:0] A_PRE_LO = ADDR_W'(OFF_PRE_LO);
  localparam logic [ADDR_W-1:0] A_PRE_HI = ADDR_W'(OFF_PRE_HI);

  logic [HALF_W-1:0] ld_lo_q, ld_hi_q, pre_lo_q, pre_hi_q;
  ctrl_t             ctrl_q;
  logic              mask_q;
  logic              locked_q;
  logic              wr_ok;
  logic              hit_load;

  assign wr_ok    = bus_we & ~locked_q;
  assign hit_load = (bus_addr == A_LD_LO) || (bus_addr == A_LD_HI) ||
                    (bus_addr == A_PRE_LO) || (bus_addr == A_PRE_HI);
  assign load_wr  = wr_ok & hit_load;
  assign clr_int  = wr_ok & (bus_addr == A_CLR) & bus_wdata[BIT_INT];
  assign clr_rst  = wr_ok & (bus_addr == A_CLR) & bus_wdata[BIT_RST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b1;
    end else if (bus_we && bus_addr == A_LOCK) begin
      locked_q <= (bus_wdata[HALF_W-1:0] != UNLOCK_KEY);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_lo_q  <= '0;
      ld_hi_q  <= '0;
      pre_lo_q <= '0;
      pre_hi_q <= '0;
      ctrl_q   <= '0;
      mask_q   <= 1'b0;
    end else if (wr_ok) begin
      case (bus_addr)
        A_LD_LO:  ld_lo_q  <= bus_wdata[HALF_W-1:0];
        A_LD_HI:  ld_hi_q  <= bus_wdata[HALF_W-1:0];
        A_PRE_LO: pre_lo_q <= bus_wdata[HALF_W-1:0];
        A_PRE_HI: pre_hi_q <= bus_wdata[HALF_W-1:0];
        A_CTRL:   ctrl_q   <= ctrl_t'(bus_wdata[3:0]);
        A_MASK:   mask_q   <= bus_wdata[0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_LD_LO:  bus_rdata = DATA_W'(ld_lo_q);
      A_LD_HI:  bus_rdata = DATA_W'(ld_hi_q);
      A_PRE_LO: bus_rdata = DATA_W'(pre_lo_q);
      A_PRE_HI: bus_rdata = DATA_W'(pre_hi_q);
      A_CTRL:   bus_rdata = DATA_W'(ctrl_q);
      A_MASK:   bus_rdata = DATA_W'(mask_q);
      A_CNT_LO: bus_rdata = DATA_W'(lower_half(cnt_val));
      A_CNT_HI: bus_rdata = DATA_W'(upper_half(cnt_val));
      A_LOCK:   bus_rdata = DATA_W'(locked_q);
      A_RAW: begin
        bus_rdata[BIT_INT]  = raw_int;
        bus_rdata[BIT_RST]  = raw_rst;
        bus_rdata[BIT_BUSY] = busy;
      end
      default:  bus_rdata = '0;
    endcase
  end

  assign ctrl     = ctrl_q;
  assign mask_int = mask_q;
  assign locked   = locked_q;
  assign load_val = join_halves(ld_hi_q, ld_lo_q);
  assign pre_val  = join_halves(pre_hi_q, pre_lo_q);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int LOAD_TICKS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] pre_val,
  input  ctrl_t            ctrl,
  input  logic             clr_int,
  input  logic             clr_rst,
  output logic [CNT_W-1:0] cnt,
  output logic             busy,
  output logic             raw_int,
  output logic             raw_rst,
  output logic             apply,
  output logic             dec,
  output logic             int_ev,
  output logic             rst_ev
);
  localparam int TK_W = $clog2(LOAD_TICKS + 1);
  localparam logic [TK_W-1:0] TK_LAST = TK_W'(LOAD_TICKS - 1);

  logic [TK_W-1:0]  tk_q;
  logic [CNT_W-1:0] cnt_q, pre_act_q, cnt_nxt;
  logic             busy_q, int_q, rst_q;

  assign apply   = busy_q & tick & ~load_wr & (tk_q == TK_LAST);
  assign dec     = tick & ctrl.run & ~apply & (cnt_q != '0);
  assign cnt_nxt = step_down(cnt_q);
  assign int_ev  = dec & (ctrl.new_mode ? (cnt_nxt == pre_act_q) : (cnt_nxt == '0));
  assign rst_ev  = dec & (cnt_nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tk_q   <= '0;
    end else if (load_wr) begin
      busy_q <= 1'b1;
      tk_q   <= '0;
    end else if (busy_q && tick) begin
      if (tk_q == TK_LAST) begin
        busy_q <= 1'b0;
        tk_q   <= '0;
      end else begin
        tk_q <= tk_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      pre_act_q <= '0;
    end else if (apply) begin
      cnt_q     <= load_val;
      pre_act_q <= pre_val;
    end else if (dec) begin
      cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      int_q <= int_ev | (int_q & ~clr_int);
      rst_q <= rst_ev | (rst_q & ~clr_rst);
    end
  end

  assign cnt     = cnt_q;
  assign busy    = busy_q;
  assign raw_int = int_q;
  assign raw_rst = rst_q;
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 32,
  parameter int LOAD_TICKS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lf_clk,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic             tick;
  logic [CNT_W-1:0] cnt_q, load_val, pre_val;
  ctrl_t            ctrl;
  logic [3:0]       ctrl_bits;
  logic             mask_int, locked, load_wr, clr_int, clr_rst;
  logic             busy, raw_int, raw_rst, apply, dec, int_ev, rst_ev;

  wdt_lf_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .lf_clk(lf_clk), .tick(tick)
  );

  wdt_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_val(cnt_q),
    .raw_int(raw_int), .raw_rst(raw_rst), .busy(busy), .ctrl(ctrl),
    .mask_int(mask_int), .load_val(load_val), .pre_val(pre_val),
    .load_wr(load_wr), .clr_int(clr_int), .clr_rst(clr_rst), .locked(locked)
  );

  wdt_core #(.LOAD_TICKS(LOAD_TICKS)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load_wr(load_wr),
    .load_val(load_val), .pre_val(pre_val), .ctrl(ctrl),
    .clr_int(clr_int), .clr_rst(clr_rst), .cnt(cnt_q), .busy(busy),
    .raw_int(raw_int), .raw_rst(raw_rst), .apply(apply), .dec(dec),
    .int_ev(int_ev), .rst_ev(rst_ev)
  );

  assign ctrl_bits = ctrl;
  assign irq_o     = raw_int & ctrl.int_en & ~mask_int;
  assign rst_req_o = raw_rst & ctrl.rst_en;
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              locked,
  input logic [3:0]        ctrl_bits,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              apply,
  input logic              dec,
  input logic              busy,
  input logic              int_ev,
  input logic              rst_ev,
  input logic              raw_int,
  input logic              raw_rst,
  input logic              irq_o,
  input logic              rst_req_o
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(8);

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!apply && !dec) |=> $stable(cnt_q));

  // R4
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(apply));

  // R6
  int_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_ev |=> raw_int);

  // R8
  rst_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ev |=> raw_rst);

  // R2
  locked_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && bus_we && bus_addr == CTRL_A) |=> $stable(ctrl_bits));

  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (raw_int && ctrl_bits[0]));

  // R8
  rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> (raw_rst && ctrl_bits[3]));
endmodule

bind wdt_top wdt_chk #(.ADDR_W(ADDR_W), .CNT_W(32)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .locked(locked), .ctrl_bits(ctrl_bits), .cnt_q(cnt_q), .apply(apply),
  .dec(dec), .busy(busy), .int_ev(int_ev), .rst_ev(rst_ev),
  .raw_int(raw_int), .raw_rst(raw_rst), .irq_o(irq_o), .rst_req_o(rst_req_o)
);

// File: tb/wdt_top_test.sv
`timescale 1ns/1ps
module wdt_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lf_clk = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, rst_req_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wdt_top uut (
    .clk(clk), .rst_n(rst_n), .lf_clk(lf_clk), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  initial forever begin
    repeat (10) @(negedge clk);
    lf_clk = ~lf_clk;
  end

  // ---------------- behavioural reference model ----------------
  bit [15:0] m_ldlo, m_ldhi, m_prlo, m_prhi;
  bit [3:0]  m_ctrl;
  bit        m_mask, m_locked, m_int, m_rst, m_busy;
  int        m_tk;
  bit [31:0] m_cnt, m_pre, m_nv;
  bit        lf_hist[$];
  bit        s_tick, s_wok, s_wl, s_app, s_dn, s_ei, s_er, s_ci, s_cr;
  int        s_a;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ldlo = 0; m_ldhi = 0; m_prlo = 0; m_prhi = 0; m_ctrl = 0; m_mask = 0;
      m_locked = 1; m_int = 0; m_rst = 0; m_busy = 0; m_tk = 0;
      m_cnt = 0; m_pre = 0;
      lf_hist = '{0, 0, 0};
    end else begin
      s_a    = int'(bus_addr);
      s_tick = lf_hist[1] && !lf_hist[2];
      lf_hist.push_front(lf_clk);
      void'(lf_hist.pop_back());
      s_wok = bus_we && !m_locked;
      s_wl  = s_wok && (s_a == 0 || s_a == 4 || s_a == 44 || s_a == 48);
      s_app = m_busy && s_tick && !s_wl && (m_tk == 2);
      s_dn  = s_tick && m_ctrl[1] && !s_app && (m_cnt != 0);
      m_nv  = m_cnt - 1;
      s_ei  = s_dn && (m_ctrl[2] ? (m_nv == m_pre) : (m_nv == 0));
      s_er  = s_dn && (m_nv == 0);
      s_ci  = s_wok && s_a == 12 && bus_wdata[0];
      s_cr  = s_wok && s_a == 12 && bus_wdata[3];
      m_int = s_ei || (m_int && !s_ci);
      m_rst = s_er || (m_rst && !s_cr);
      if (s_app) begin
        m_cnt = {m_ldhi, m_ldlo};
        m_pre = {m_prhi, m_prlo};
      end else if (s_dn) m_cnt = m_nv;
      if (s_wl) begin m_busy = 1; m_tk = 0; end
      else if (m_busy && s_tick) begin
        if (m_tk == 2) begin m_busy = 0; m_tk = 0; end
        else m_tk++;
      end
      if (s_wok) begin
        case (s_a)
          0:  m_ldlo = bus_wdata[15:0];
          4:  m_ldhi = bus_wdata[15:0];
          44: m_prlo = bus_wdata[15:0];
          48: m_prhi = bus_wdata[15:0];
          8:  m_ctrl = bus_wdata[3:0];
          20: m_mask = bus_wdata[0];
          default: ;
        endcase
      end
      if (bus_we && s_a == 32) m_locked = (bus_wdata[15:0] != 16'hE551);
    end
  end

  function automatic bit [31:0] m_read(int a);
    case (a)
      0:  return {16'h0, m_ldlo};
      4:  return {16'h0, m_ldhi};
      44: return {16'h0, m_prlo};
      48: return {16'h0, m_prhi};
      8:  return {28'h0, m_ctrl};
      20: return {31'h0, m_mask};
      24: return {16'h0, m_cnt[15:0]};
      28: return {16'h0, m_cnt[31:16]};
      32: return {31'h0, m_locked};
      16: return {27'h0, m_busy, m_rst, 2'b00, m_int};
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      32: return "R2";
      16: return "R4";
      24, 28: return "R5";
      12: return "R10";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(string req, bit [31:0] act, bit [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model, sampled mid-cycle
  always @(posedge clk) begin
    #6;
    cycles++;
    if (!finished) begin
      chk(tag_of(int'(bus_addr)), bus_rdata, m_read(int'(bus_addr)));
      chk("R9", {31'h0, irq_o}, {31'h0, m_int && m_ctrl[0] && !m_mask});
      chk("R8", {31'h0, rst_req_o}, {31'h0, m_rst && m_ctrl[3]});
    end
    if (cycles > 150000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(int a, bit [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd_chk(int a, bit [31:0] exp, string req);
    @(negedge clk);
    bus_addr = 6'(a);
    @(posedge clk);
    #6;
    chk(req, bus_rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(4);
    rst_n = 1;
    // R1 reset state
    rd_chk(32, 1, "R1");
    rd_chk(8, 0, "R1");
    rd_chk(16, 0, "R1");
    rd_chk(24, 0, "R1");
    chk("R1", {30'h0, irq_o, rst_req_o}, 0);

    // R2 locked writes ignored, key handling
    wr(8, 32'hF);
    rd_chk(8, 0, "R2");
    wr(32, 32'hE551);
    rd_chk(32, 0, "R2");
    wr(32, 32'h1234);
    rd_chk(32, 1, "R2");
    wr(0, 32'h77);
    rd_chk(0, 0, "R2");
    wr(32, 32'hE551);

    // R3 / R4 split load and handover
    wr(4, 32'h2); wr(0, 32'h5); wr(48, 0); wr(44, 0);
    rd_chk(16, 32'h10, "R4");
    idle(80);
    rd_chk(16, 0, "R4");
    rd_chk(28, 32'h2, "R3");
    rd_chk(24, 32'h5, "R3");

    // R6 / R9 threshold interrupt in new mode
    wr(4, 0); wr(0, 32'h30); wr(44, 32'h10);
    idle(80);
    wr(8, 32'hF);
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #6;
      if (irq_o) break;
    end
    chk("R9", {31'h0, irq_o}, 1);
    rd_chk(24, 32'h10, "R6");
    wr(20, 1);
    chk("R9", {31'h0, irq_o}, 0);
    wr(12, 1);
    rd_chk(16, 0, "R10");
    wr(20, 0);

    // R11 keep-alive reload while running
    wr(0, 32'h30);
    idle(80);
    bus_addr = 6'd24;
    @(posedge clk); #6;
    chk("R11", {31'h0, bus_rdata[15:0] > 16'h2A && bus_rdata[15:0] <= 16'h30}, 1);

    // R8 expiry, R5 hold at zero, R10 clear
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #6;
      if (rst_req_o) break;
    end
    chk("R8", {31'h0, rst_req_o}, 1);
    rd_chk(24, 0, "R8");
    idle(100);
    rd_chk(24, 0, "R5");
    wr(12, 32'h9);
    rd_chk(16, 0, "R10");
    chk("R10", {31'h0, rst_req_o}, 0);
    rd_chk(12, 0, "R10");

    // R7 legacy mode: no interrupt at the threshold, only at zero
    wr(8, 0);
    wr(0, 32'h8); wr(44, 32'h4);
    idle(80);
    wr(8, 32'hB);
    bus_addr = 6'd24;
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #6;
      if (bus_rdata[15:0] <= 16'h3) break;
    end
    rd_chk(16, 0, "R7");
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #6;
      if (rst_req_o) break;
    end
    rd_chk(16, 32'h9, "R7");
    wr(12, 32'h9);

    // R5 counting disabled holds the count
    wr(8, 0);
    wr(0, 32'h20);
    idle(80);
    rd_chk(24, 32'h20, "R5");
    idle(100);
    rd_chk(24, 32'h20, "R5");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule